// File: doc/BRIEF.md
# Four-Way Cache Read Lookup with Sequential Way Reuse

This block is the read side of a four-way set-associative cache. A read carries a virtual address, whose set bits select the set, and a physical tag, which is compared against the stored tag of each way. One cycle after the request it reports a hit, with the way and a 64-bit pair of words from that way, or a miss, with the way picked for refill by a round-robin pointer. Tag and data storage are held inside the block, one array per way. A whole line is written through a one-cycle fill port, and a line is invalidated through a second port.

Power is saved on reads that walk through a line. When a request is marked sequential and falls in the same line as the last read that hit, the tag storage is left idle and only the data array of the remembered way is enabled. Any fill or invalidation forgets the remembered way, so the next read does a full lookup.

Top module: `cache_rd_lookup`

## Requirements
- R1: Every request receives exactly one of rd_hit or rd_miss in the following cycle. The set comes from address bits [4+log2(sets):5], and the tag compared is rd_ptag.
- R2: On a hit, rd_way gives the hitting way and rd_data gives the word pair selected by address bits [4:3]. rd_data[31:0] holds the even word 2p and rd_data[63:32] holds word 2p+1 of the line.
- R3: On a miss, rd_way gives the refill way from a two-bit round-robin pointer. The pointer starts at 0 and steps by one, wrapping from 3 to 0, after each miss. rd_data is 0 on a miss.
- R4: A full lookup raises tag_ram_en and enables all four bits of data_ram_en in the request cycle.
- R5: A sequential request whose line address (bits [31:5]) equals that of the last hitting read leaves tag_ram_en low and enables only data_ram_en[way of that hit]. It returns a hit on that way.
- R6: A sequential request to a different line, or one that follows a miss, does a full lookup.
- R7: A fill writes all eight words and the tag of the addressed set and way and marks the line valid, so a later read with that set and tag hits it. Word k of the line is taken from fill_data[32k+31:32k].
- R8: An invalidation clears the valid bit of one set and way, so a later read of that line misses.
- R9: A fill or invalidation makes the request in the same cycle, and the next request, do a full lookup.
- R10: After reset every line is invalid, no way is remembered, the refill pointer is 0, and no hit or miss is reported.
- R11: A cycle without a request enables no storage, and no hit or miss follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request |
| rd_seq | input | 1 | Read continues the previous access |
| rd_vaddr | input | ADDR_W-3 | Virtual address bits [ADDR_W-1:3] |
| rd_ptag | input | TAG_W | Physical tag of the read |
| fill_en | input | 1 | Write a whole line |
| fill_way | input | 2 | Way to fill |
| fill_idx | input | IDX_W | Set to fill |
| fill_ptag | input | TAG_W | Tag stored by the fill |
| fill_data | input | 256 | Eight words, word 0 in the low bits |
| inv_en | input | 1 | Invalidate one line |
| inv_way | input | 2 | Way to invalidate |
| inv_idx | input | IDX_W | Set to invalidate |
| tag_ram_en | output | 1 | Tag storage read this cycle |
| data_ram_en | output | 4 | Per-way data storage enables this cycle |
| rd_hit | output | 1 | Previous request hit |
| rd_miss | output | 1 | Previous request missed |
| rd_way | output | 2 | Hitting way or refill way |
| rd_data | output | 64 | Word pair on a hit, zero otherwise |

## Verification
The bench targets back-to-back sequential reads straight after a full-lookup hit. A design that did not pass the fresh hit forward would fall back to a full lookup, or would enable a stale way. It also issues sequential reads that cross a line boundary or follow a miss, where a design that ignored the line compare would return data from the wrong line. Sequential reads placed right after fills and invalidations would expose a design that kept its remembered way. The run ends with a long mixed stream that wraps the refill pointer and hits every word pair, so a swapped word order or an off-by-one pointer shows up.

// File: rtl/cache_rd_pkg.sv
package cache_rd_pkg;
    localparam int NWAYS      = 4;
    localparam int WAY_IW     = 2;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 8;
    localparam int PAIRS      = LINE_WORDS / 2;
    localparam int PAIR_IW    = 2;
    localparam int PAIR_W     = 2 * WORD_W;
    localparam int LINE_BITS  = LINE_WORDS * WORD_W;
    localparam int OFF_W      = 5;

    function automatic logic [NWAYS-1:0] way_onehot(input logic [WAY_IW-1:0] w);
        return NWAYS'(1) << w;
    endfunction
endpackage

// File: rtl/cache_tag_way.sv
module cache_tag_way
    import cache_rd_pkg::*;
#(
    parameter int SETS  = 32,
    parameter int IDX_W = 5,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_en,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic             hit_q
);
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_d, vld_q;
    logic             hit_d;

    always_comb begin
        vld_d = vld_q;
        if (clr_en) vld_d[clr_idx] = 1'b0;
        if (wr_en)  vld_d[wr_idx]  = 1'b1;
        hit_d = lk_en && vld_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            hit_q <= 1'b0;
        end else begin
            vld_q <= vld_d;
            hit_q <= hit_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_idx] <= wr_tag;
    end
endmodule

// File: rtl/cache_data_way.sv
module cache_data_way
    import cache_rd_pkg::*;
#(
    parameter int SETS  = 32,
    parameter int IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [PAIR_IW-1:0]   rd_pair,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [LINE_BITS-1:0] wr_line,
    output logic [PAIR_W-1:0]    rdata_q
);
    logic [PAIR_W-1:0] mem [SETS][PAIRS];

    always_ff @(posedge clk) begin
        if (rd_en) rdata_q <= mem[rd_idx][rd_pair];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int p = 0; p < PAIRS; p++) begin
                mem[wr_idx][p] <= wr_line[p*PAIR_W +: PAIR_W];
            end
        end
    end
endmodule

// File: rtl/cache_rd_lookup.sv
module cache_rd_lookup
    import cache_rd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WAY_KB = 1,
    localparam int SETS   = WAY_KB * 1024 / (LINE_WORDS * 4),
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic                 rd_seq,
    input  logic [ADDR_W-1:3]    rd_vaddr,
    input  logic [TAG_W-1:0]     rd_ptag,
    input  logic                 fill_en,
    input  logic [WAY_IW-1:0]    fill_way,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [TAG_W-1:0]     fill_ptag,
    input  logic [LINE_BITS-1:0] fill_data,
    input  logic                 inv_en,
    input  logic [WAY_IW-1:0]    inv_way,
    input  logic [IDX_W-1:0]     inv_idx,
    output logic                 tag_ram_en,
    output logic [NWAYS-1:0]     data_ram_en,
    output logic                 rd_hit,
    output logic                 rd_miss,
    output logic [WAY_IW-1:0]    rd_way,
    output logic [PAIR_W-1:0]    rd_data
);
    typedef struct packed {
        logic              last_vld;
        logic [WAY_IW-1:0] last_way;
        logic [LINE_W-1:0] last_line;
        logic [WAY_IW-1:0] victim;
        logic              full;
        logic              seq;
        logic [WAY_IW-1:0] seq_way;
        logic              pend_ok;
        logic [LINE_W-1:0] pend_line;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [IDX_W-1:0]   rd_idx;
    logic [PAIR_IW-1:0] rd_pair;
    logic [LINE_W-1:0]  rd_line;
    logic [NWAYS-1:0]   hit_vec;
    logic [PAIR_W-1:0]  way_rdata [NWAYS];

    assign rd_idx  = rd_vaddr[OFF_W+IDX_W-1:OFF_W];
    assign rd_pair = rd_vaddr[OFF_W-1:3];
    assign rd_line = rd_vaddr[ADDR_W-1:OFF_W];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        cache_tag_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_tag (
            .clk     (clk),
            .rst_n   (rst_n),
            .lk_en   (tag_ram_en),
            .lk_idx  (rd_idx),
            .lk_tag  (rd_ptag),
            .wr_en   (fill_en && (fill_way == WAY_IW'(w))),
            .wr_idx  (fill_idx),
            .wr_tag  (fill_ptag),
            .clr_en  (inv_en && (inv_way == WAY_IW'(w))),
            .clr_idx (inv_idx),
            .hit_q   (hit_vec[w])
        );
        cache_data_way #(.SETS(SETS), .IDX_W(IDX_W)) i_data (
            .clk     (clk),
            .rd_en   (data_ram_en[w]),
            .rd_idx  (rd_idx),
            .rd_pair (rd_pair),
            .wr_en   (fill_en && (fill_way == WAY_IW'(w))),
            .wr_idx  (fill_idx),
            .wr_line (fill_data),
            .rdata_q (way_rdata[w])
        );
    end

    logic              any_hit;
    logic [WAY_IW-1:0] hit_way;
    logic              eff_vld;
    logic [WAY_IW-1:0] eff_way;
    logic [LINE_W-1:0] eff_line;
    logic              seq_ok;
    logic              clear_mem;

    always_comb begin
        // lowest-numbered hitting way wins
        any_hit = |hit_vec;
        hit_way = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_IW'(w);
        end

        // a lookup answered this cycle is forwarded so a back-to-back
        // sequential read can reuse its way at once
        eff_vld  = c_q.full ? (c_q.pend_ok && any_hit) : c_q.last_vld;
        eff_way  = c_q.full ? hit_way : c_q.last_way;
        eff_line = c_q.full ? c_q.pend_line : c_q.last_line;

        clear_mem = fill_en || inv_en;
        seq_ok    = rd_req && rd_seq && eff_vld && (rd_line == eff_line) && !clear_mem;

        tag_ram_en  = rd_req && !seq_ok;
        data_ram_en = seq_ok ? way_onehot(eff_way) : (rd_req ? '1 : '0);

        c_d           = c_q;
        c_d.last_vld  = clear_mem ? 1'b0 : eff_vld;
        c_d.last_way  = eff_way;
        c_d.last_line = eff_line;
        c_d.victim    = c_q.victim + WAY_IW'(c_q.full && !any_hit);
        c_d.full      = tag_ram_en;
        c_d.seq       = seq_ok;
        c_d.seq_way   = eff_way;
        c_d.pend_ok   = !clear_mem;
        c_d.pend_line = rd_line;

        rd_hit  = c_q.seq || (c_q.full && any_hit);
        rd_miss = c_q.full && !any_hit;
        if (c_q.seq)     rd_way = c_q.seq_way;
        else if (any_hit) rd_way = hit_way;
        else             rd_way = c_q.victim;
        rd_data = rd_hit ? way_rdata[rd_way] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/cache_rd_lookup_chk.sv
module cache_rd_lookup_chk
    import cache_rd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              fill_en,
    input logic              inv_en,
    input logic              tag_ram_en,
    input logic [NWAYS-1:0]  data_ram_en,
    input logic              rd_hit,
    input logic              rd_miss,
    input logic [PAIR_W-1:0] rd_data
);
    a_r1_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_hit ^ rd_miss));
    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_hit && rd_miss));
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !(rd_hit || rd_miss));
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |-> (data_ram_en == '0 && !tag_ram_en));
    a_r4_full_all_ways: assert property (@(posedge clk) disable iff (!rst_n)
        tag_ram_en |-> (rd_req && data_ram_en == '1));
    a_r5_single_way: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !tag_ram_en) |-> $countones(data_ram_en) == 1);
    a_r5_seq_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !tag_ram_en) |=> rd_hit);
    a_r9_forget_way: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en || inv_en) |=> (!rd_req || tag_ram_en));
    a_r3_miss_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_miss |-> rd_data == '0);
endmodule

bind cache_rd_lookup cache_rd_lookup_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .fill_en     (fill_en),
    .inv_en      (inv_en),
    .tag_ram_en  (tag_ram_en),
    .data_ram_en (data_ram_en),
    .rd_hit      (rd_hit),
    .rd_miss     (rd_miss),
    .rd_data     (rd_data)
);

// File: tb/test_cache_rd_lookup.sv
module test_cache_rd_lookup;
    localparam int CLK_PERIOD = 10;
    localparam int SETS  = 32;
    localparam int IDX_W = 5;
    localparam int TAG_W = 22;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_req = 0, rd_seq = 0;
    logic [31:0]  va = '0;
    logic [TAG_W-1:0] rd_ptag = '0, fill_ptag = '0;
    logic         fill_en = 0, inv_en = 0;
    logic [1:0]   fill_way = '0, inv_way = '0;
    logic [IDX_W-1:0] fill_idx = '0, inv_idx = '0;
    logic [255:0] fill_data = '0;
    logic         tag_ram_en, rd_hit, rd_miss;
    logic [3:0]   data_ram_en;
    logic [1:0]   rd_way;
    logic [63:0]  rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_rd_lookup i_cache_rd_lookup (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_seq(rd_seq),
        .rd_vaddr(va[31:3]), .rd_ptag(rd_ptag),
        .fill_en(fill_en), .fill_way(fill_way), .fill_idx(fill_idx),
        .fill_ptag(fill_ptag), .fill_data(fill_data),
        .inv_en(inv_en), .inv_way(inv_way), .inv_idx(inv_idx),
        .tag_ram_en(tag_ram_en), .data_ram_en(data_ram_en),
        .rd_hit(rd_hit), .rd_miss(rd_miss), .rd_way(rd_way), .rd_data(rd_data)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference
    bit          m_vld  [4][SETS];
    logic [TAG_W-1:0] m_tag [4][SETS];
    logic [31:0] m_word [4][SETS][8];
    bit          m_last_vld = 0;
    int          m_last_way = 0;
    logic [26:0] m_last_line = '0;
    int          m_victim = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    function automatic logic [31:0] rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // one clock: check enables in the request cycle, then the answer after the edge
    task automatic tick(string rq);
        bit seqok, e_hit, e_miss;
        int e_way, idx, pr;
        logic [3:0] e_den;
        logic [63:0] e_data;
        #1;
        idx = int'(va[9:5]);
        pr  = int'(va[4:3]);
        seqok = rd_req && rd_seq && m_last_vld && (va[31:5] == m_last_line) && !fill_en && !inv_en;
        e_den = seqok ? 4'(1 << m_last_way) : (rd_req ? 4'hf : 4'h0);
        chk(tag_ram_en == (rd_req && !seqok), rq, seqok ? "R5 tag enable" : "R4 tag enable",
            64'(tag_ram_en), 64'(rd_req && !seqok));
        chk(data_ram_en == e_den, rq, rd_req ? "R5/R4 data enables" : "R11 data enables",
            64'(data_ram_en), 64'(e_den));
        e_hit = 0; e_miss = 0; e_way = 0; e_data = '0;
        if (seqok) begin
            e_hit = 1; e_way = m_last_way;
        end else if (rd_req) begin
            for (int w = 3; w >= 0; w--)
                if (m_vld[w][idx] && m_tag[w][idx] == rd_ptag) begin e_hit = 1; e_way = w; end
            if (e_hit) begin
                m_last_vld = 1; m_last_way = e_way; m_last_line = va[31:5];
            end else begin
                e_miss = 1; e_way = m_victim; m_victim = (m_victim + 1) % 4; m_last_vld = 0;
            end
        end
        if (e_hit) e_data = {m_word[e_way][idx][2*pr+1], m_word[e_way][idx][2*pr]};
        if (fill_en || inv_en) m_last_vld = 0;
        @(posedge clk);
        if (inv_en) m_vld[inv_way][inv_idx] = 0;
        if (fill_en) begin
            m_vld[fill_way][fill_idx] = 1;
            m_tag[fill_way][fill_idx] = fill_ptag;
            for (int k = 0; k < 8; k++) m_word[fill_way][fill_idx][k] = fill_data[32*k +: 32];
        end
        #1;
        chk(rd_hit == e_hit, rq, "R1 hit", 64'(rd_hit), 64'(e_hit));
        chk(rd_miss == e_miss, rq, "R1 miss", 64'(rd_miss), 64'(e_miss));
        if (e_hit || e_miss)
            chk(rd_way == 2'(e_way), rq, e_hit ? "R2 way" : "R3 refill way", 64'(rd_way), 64'(e_way));
        chk(rd_data == e_data, rq, "R2 data", rd_data, e_data);
        rd_req = 0; rd_seq = 0; fill_en = 0; inv_en = 0;
    endtask

    task automatic t_read(string rq, logic [31:0] a, logic [TAG_W-1:0] t, bit s);
        rd_req = 1; rd_seq = s; va = a; rd_ptag = t;
        tick(rq);
    endtask

    task automatic set_fill(int w, int idx, logic [TAG_W-1:0] t);
        fill_en = 1; fill_way = 2'(w); fill_idx = IDX_W'(idx); fill_ptag = t;
        for (int k = 0; k < 8; k++) fill_data[32*k +: 32] = rnd();
    endtask

    task automatic t_fill(string rq, int w, int idx, logic [TAG_W-1:0] t);
        set_fill(w, idx, t);
        tick(rq);
    endtask

    task automatic t_inv(string rq, int w, int idx);
        inv_en = 1; inv_way = 2'(w); inv_idx = IDX_W'(idx);
        tick(rq);
    endtask

    function automatic logic [31:0] addr(int vhi, int idx, int pr);
        return {22'(vhi), 5'(idx), 2'(pr), 3'b000};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: idle after reset
        chk(!rd_hit && !rd_miss, "R10", "reset response", 64'({rd_hit, rd_miss}), 64'(0));
        chk(!tag_ram_en && data_ram_en == 0, "R10", "reset enables", 64'({tag_ram_en, data_ram_en}), 64'(0));
        rst_n = 1;
        // R10/R3: empty cache misses, pointer from 0 rotating
        t_read("R10", addr(0, 3, 0), 22'h00A, 0);
        t_read("R3", addr(0, 3, 1), 22'h00A, 0);
        // R7: fill then full lookups on every pair
        t_fill("R7", 2, 3, 22'h00A);
        for (int p = 0; p < 4; p++) t_read("R7", addr(0, 3, p), 22'h00A, 0);
        // R5: sequential walk reusing way 2, starting back-to-back after a hit
        for (int p = 0; p < 4; p++) t_read("R5", addr(0, 3, p), 22'h00A, 1);
        // R6: sequential into another line, then sequential after that miss
        t_read("R6", addr(0, 4, 0), 22'h00A, 1);
        t_read("R6", addr(0, 4, 1), 22'h00A, 1);
        // R2: several ways in one set, pick by tag
        t_fill("R2", 0, 9, 22'h111);
        t_fill("R2", 1, 9, 22'h222);
        t_fill("R2", 3, 9, 22'h333);
        t_read("R2", addr(5, 9, 2), 22'h222, 0);
        t_read("R2", addr(5, 9, 3), 22'h333, 0);
        t_read("R5", addr(5, 9, 1), 22'h333, 1);
        // R9: fill forgets the remembered way; sequential read afterwards looks up
        t_fill("R9", 0, 20, 22'h3FF);
        t_read("R9", addr(5, 9, 0), 22'h333, 1);
        t_read("R5", addr(5, 9, 2), 22'h333, 1);
        // R9: sequential request alongside an invalidation
        rd_req = 1; rd_seq = 1; va = addr(5, 9, 1); rd_ptag = 22'h333;
        inv_en = 1; inv_way = 2'd1; inv_idx = 5'd9;
        tick("R9");
        // R8: invalidated line now misses
        t_read("R8", addr(5, 9, 0), 22'h222, 0);
        t_inv("R8", 3, 9);
        t_read("R8", addr(5, 9, 0), 22'h333, 1);
        // R11: idle cycles
        for (int i = 0; i < 3; i++) tick("R11");
        // mixed stream
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = rnd();
            if (r[3:0] < 2) begin
                set_fill(int'(r[5:4]), int'(r[6]), 22'(r[7] + 1));
                tick("R7");
            end else if (r[3:0] == 2) begin
                inv_en = 1; inv_way = r[5:4]; inv_idx = 5'(r[6]);
                tick("R8");
            end else if (r[3:0] < 5) begin
                tick("R11");
            end else begin
                if (r[8] && m_last_vld)
                    va = {m_last_line, r[10:9], 3'b000};
                else
                    va = addr(int'(r[11]), int'(r[6]), int'(r[10:9]));
                rd_req = 1; rd_seq = r[8] | r[12]; rd_ptag = 22'(r[7] + 1);
                tick("R1");
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule